// File: doc/BRIEF.md
# Operand Addressing-Mode Resolver

This block turns a 6-bit operand code from a 16-bit processor's instruction word into a description of where the operand lives. The result is one of three things: a register inside the core (one of eight general registers, the stack pointer, the program counter or the overflow register), a memory address, or an immediate value. Alongside that target it reports the pointer side effects the operand implies. These are a stack pointer update for push and pop, and a program counter increment when the operand consumes the word that follows the instruction. It also flags the extra cycle that such a word costs.

The surrounding sequencer feeds in the operand code, whether the operand is the destination, the eight register values, the current SP and PC, and the word at PC. It then performs the access itself. When an instruction carries two operands, the sequencer resolves the a operand first and applies its SP/PC side effects before it presents the b operand. A literal used as a destination is turned into a discard target, so the write it would cause has no effect. All address arithmetic wraps modulo 2^16. With the default `REG_OUT = 1`, results are registered once.

Top module: `opr_resolver`

## Requirements
- R1: Codes 0x00 to 0x07 give target kind REG (encoding 0), with the register index equal to the low three code bits, in the order A, B, C, X, Y, Z, I, J.
- R2: Codes 0x08 to 0x0F give kind MEM (encoding 4), with the address equal to the value of the register named by the low three code bits.
- R3: Codes 0x10 to 0x17 give kind MEM, with the address equal to next word plus the selected register modulo 2^16. They request PC = PC+1 (wrapping 0xFFFF to 0x0000) and assert the extra-cycle flag.
- R4: Code 0x18 (pop) gives kind MEM at address SP and requests SP = SP+1, wrapping 0xFFFF to 0x0000.
- R5: Code 0x19 (peek) gives kind MEM at address SP and requests no SP change.
- R6: Code 0x1A (push) gives kind MEM at address SP-1 and requests SP = SP-1, wrapping 0x0000 to 0xFFFF.
- R7: Codes 0x1B, 0x1C and 0x1D give kinds SP (1), PC (2) and O (3).
- R8: Code 0x1E gives kind MEM at the address held in the next word. It requests PC+1 and asserts the extra-cycle flag.
- R9: Code 0x1F as a source gives kind LIT (5) with the next word as the value. It requests PC+1 and asserts the extra-cycle flag.
- R10: Codes 0x20 to 0x3F as a source give kind LIT with the value code minus 0x20 (0 to 31).
- R11: A literal code (0x1F or 0x20 to 0x3F) as a destination gives kind DISCARD (6) with literal value 0. Code 0x1F still requests PC+1 and the extra cycle.
- R12: Codes that do not use the next word request no PC change (pc_upd 0, pc_next = PC, extra cycle 0). Codes other than push and pop request no SP change (sp_upd 0, sp_next = SP).
- R13: Outputs appear one clock after their inputs. While reset is asserted, every output is zero.
- R14: Fields a kind does not use are zero: the register index unless the kind is REG, the address unless it is MEM, and the literal value unless it is LIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 6 | Operand code |
| is_dest | input | 1 | 1 when the operand is the destination |
| reg_file | input | NREG*DW | Register values, register i at bits [i*DW +: DW] |
| sp_in | input | DW | Current stack pointer |
| pc_in | input | DW | Current program counter, already past the instruction word |
| next_word | input | DW | Memory word at pc_in |
| tgt_kind | output | 3 | Target kind encoding |
| tgt_reg | output | $clog2(NREG) | General register index |
| tgt_addr | output | DW | Memory address |
| lit_value | output | DW | Immediate value |
| sp_upd | output | 1 | Stack pointer update request |
| sp_next | output | DW | Stack pointer after the operand |
| pc_upd | output | 1 | Program counter update request |
| pc_next | output | DW | Program counter after the operand |
| extra_cycle | output | 1 | Operand costs one extra cycle |

## Verification
The bench sweeps all 64 codes, in both source and destination role, under register, SP, PC and next-word patterns that push every adder across its wrap point. It therefore catches an indexed address that saturates or carries into a wrong width, a pop from 0xFFFF or a push at 0x0000 that does not wrap, and a PC increment that fails to roll over. Comparing every field on every vector also exposes the quieter faults. A destination literal that still reports LIT, a discarded next-word literal that stops consuming its word, a peek that moves SP, or stale address or index bits left on a kind that does not use them all produce a mismatch. A check made just before a clock edge finds a resolver that answers combinationally when it should be registered.

// File: rtl/opr_pkg.sv
`timescale 1ns/1ps
package opr_pkg;

   localparam int CODE_W   = 6;
   localparam int LIT_BITS = CODE_W - 1;

   typedef enum logic [2:0] {
      TGT_REG     = 3'd0,
      TGT_SP      = 3'd1,
      TGT_PC      = 3'd2,
      TGT_OVF     = 3'd3,
      TGT_MEM     = 3'd4,
      TGT_LIT     = 3'd5,
      TGT_DISCARD = 3'd6
   } tgt_kind_e;

   typedef enum logic [3:0] {
      M_GPR, M_IND, M_IDX, M_POP, M_PEEK, M_PUSH,
      M_SPR, M_PCR, M_OVR, M_NWADDR, M_NWLIT, M_SLIT
   } opr_mode_e;

   function automatic logic mode_uses_word(opr_mode_e m);
      return (m == M_IDX) || (m == M_NWADDR) || (m == M_NWLIT);
   endfunction

   function automatic logic mode_is_mem(opr_mode_e m);
      return (m == M_IND) || (m == M_IDX) || (m == M_POP) ||
             (m == M_PEEK) || (m == M_PUSH) || (m == M_NWADDR);
   endfunction

endpackage

// File: rtl/opr_mode_decode.sv
`timescale 1ns/1ps
module opr_mode_decode
   import opr_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic [CODE_W-1:0] code,
   output opr_mode_e         mode,
   output logic [SEL_W-1:0]  sel
);

   always_comb begin
      sel = code[SEL_W-1:0];
      unique case (code[CODE_W-1:SEL_W])
         3'b000: mode = M_GPR;
         3'b001: mode = M_IND;
         3'b010: mode = M_IDX;
         3'b011: begin
            unique case (code[SEL_W-1:0])
               3'd0:    mode = M_POP;
               3'd1:    mode = M_PEEK;
               3'd2:    mode = M_PUSH;
               3'd3:    mode = M_SPR;
               3'd4:    mode = M_PCR;
               3'd5:    mode = M_OVR;
               3'd6:    mode = M_NWADDR;
               default: mode = M_NWLIT;
            endcase
         end
         default: mode = M_SLIT;
      endcase
   end

endmodule

// File: rtl/opr_addr_gen.sv
`timescale 1ns/1ps
module opr_addr_gen
   import opr_pkg::*;
#(
   parameter int DW    = 16,
   parameter int NREG  = 8,
   parameter int SEL_W = $clog2(NREG)
) (
   input  opr_mode_e          mode,
   input  logic [SEL_W-1:0]   sel,
   input  logic [NREG*DW-1:0] reg_file,
   input  logic [DW-1:0]      sp,
   input  logic [DW-1:0]      nword,
   output logic [DW-1:0]      addr
);

   localparam logic [DW-1:0] ONE = DW'(1);

   logic [DW-1:0] regs [NREG];
   logic [DW-1:0] reg_val;

   for (genvar g = 0; g < NREG; g++) begin : g_unpack
      assign regs[g] = reg_file[g*DW +: DW];
   end

   assign reg_val = regs[sel];

   always_comb begin
      unique case (mode)
         M_IND:           addr = reg_val;
         M_IDX:           addr = nword + reg_val;
         M_POP, M_PEEK:   addr = sp;
         M_PUSH:          addr = sp - ONE;
         M_NWADDR:        addr = nword;
         default:         addr = '0;
      endcase
   end

endmodule

// File: rtl/opr_ptr_update.sv
`timescale 1ns/1ps
module opr_ptr_update
   import opr_pkg::*;
#(
   parameter int DW = 16
) (
   input  opr_mode_e     mode,
   input  logic [DW-1:0] sp,
   input  logic [DW-1:0] pc,
   output logic          sp_upd,
   output logic [DW-1:0] sp_next,
   output logic          pc_upd,
   output logic [DW-1:0] pc_next,
   output logic          extra
);

   localparam logic [DW-1:0] ONE = DW'(1);

   always_comb begin
      sp_upd  = 1'b0;
      sp_next = sp;
      if (mode == M_POP) begin
         sp_upd  = 1'b1;
         sp_next = sp + ONE;
      end else if (mode == M_PUSH) begin
         sp_upd  = 1'b1;
         sp_next = sp - ONE;
      end
   end

   always_comb begin
      pc_upd  = mode_uses_word(mode);
      extra   = pc_upd;
      pc_next = pc_upd ? (pc + ONE) : pc;
   end

endmodule

// File: rtl/opr_resolver.sv
`timescale 1ns/1ps
module opr_resolver
   import opr_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NREG    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [5:0]               op_code,
   input  logic                     is_dest,
   input  logic [NREG*DW-1:0]       reg_file,
   input  logic [DW-1:0]            sp_in,
   input  logic [DW-1:0]            pc_in,
   input  logic [DW-1:0]            next_word,
   output logic [2:0]               tgt_kind,
   output logic [$clog2(NREG)-1:0]  tgt_reg,
   output logic [DW-1:0]            tgt_addr,
   output logic [DW-1:0]            lit_value,
   output logic                     sp_upd,
   output logic [DW-1:0]            sp_next,
   output logic                     pc_upd,
   output logic [DW-1:0]            pc_next,
   output logic                     extra_cycle
);

   localparam int SEL_W = $clog2(NREG);

   if (NREG != 8) begin : g_bad_nreg
      $error("opr_resolver: operand encoding needs exactly 8 general registers");
   end
   if (DW < LIT_BITS) begin : g_bad_dw
      $error("opr_resolver: data width too small for short literals");
   end

   opr_mode_e        mode;
   logic [SEL_W-1:0] sel;
   logic [DW-1:0]    addr_raw;

   opr_mode_decode #(.SEL_W(SEL_W)) u_dec (
      .code (op_code),
      .mode (mode),
      .sel  (sel)
   );

   opr_addr_gen #(.DW(DW), .NREG(NREG), .SEL_W(SEL_W)) u_addr (
      .mode     (mode),
      .sel      (sel),
      .reg_file (reg_file),
      .sp       (sp_in),
      .nword    (next_word),
      .addr     (addr_raw)
   );

   logic          sp_upd_c, pc_upd_c, extra_c;
   logic [DW-1:0] sp_next_c, pc_next_c;

   opr_ptr_update #(.DW(DW)) u_ptr (
      .mode    (mode),
      .sp      (sp_in),
      .pc      (pc_in),
      .sp_upd  (sp_upd_c),
      .sp_next (sp_next_c),
      .pc_upd  (pc_upd_c),
      .pc_next (pc_next_c),
      .extra   (extra_c)
   );

   tgt_kind_e        kind_c;
   logic [SEL_W-1:0] reg_c;
   logic [DW-1:0]    lit_c;
   logic [DW-1:0]    addr_c;
   logic             is_lit;

   always_comb begin
      is_lit = (mode == M_NWLIT) || (mode == M_SLIT);
      unique case (mode)
         M_GPR:   kind_c = TGT_REG;
         M_SPR:   kind_c = TGT_SP;
         M_PCR:   kind_c = TGT_PC;
         M_OVR:   kind_c = TGT_OVF;
         default: kind_c = is_lit ? (is_dest ? TGT_DISCARD : TGT_LIT) : TGT_MEM;
      endcase
      reg_c  = (mode == M_GPR) ? sel : '0;
      addr_c = mode_is_mem(mode) ? addr_raw : '0;
      if (!is_lit || is_dest)  lit_c = '0;
      else if (mode == M_NWLIT) lit_c = next_word;
      else                      lit_c = DW'(op_code[LIT_BITS-1:0]);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tgt_kind    <= '0;
            tgt_reg     <= '0;
            tgt_addr    <= '0;
            lit_value   <= '0;
            sp_upd      <= 1'b0;
            sp_next     <= '0;
            pc_upd      <= 1'b0;
            pc_next     <= '0;
            extra_cycle <= 1'b0;
         end else begin
            tgt_kind    <= kind_c;
            tgt_reg     <= reg_c;
            tgt_addr    <= addr_c;
            lit_value   <= lit_c;
            sp_upd      <= sp_upd_c;
            sp_next     <= sp_next_c;
            pc_upd      <= pc_upd_c;
            pc_next     <= pc_next_c;
            extra_cycle <= extra_c;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk  = clk ^ rst_n;
      assign tgt_kind    = kind_c;
      assign tgt_reg     = reg_c;
      assign tgt_addr    = addr_c;
      assign lit_value   = lit_c;
      assign sp_upd      = sp_upd_c;
      assign sp_next     = sp_next_c;
      assign pc_upd      = pc_upd_c;
      assign pc_next     = pc_next_c;
      assign extra_cycle = extra_c;
   end

endmodule

// File: rtl/opr_resolver_chk.sv
`timescale 1ns/1ps
module opr_resolver_chk
   import opr_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NREG    = 8,
   parameter bit REG_OUT = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [5:0]               op_code,
   input logic                     is_dest,
   input logic [NREG*DW-1:0]       reg_file,
   input logic [DW-1:0]            sp_in,
   input logic [DW-1:0]            pc_in,
   input logic [DW-1:0]            next_word,
   input logic [2:0]               tgt_kind,
   input logic [$clog2(NREG)-1:0]  tgt_reg,
   input logic [DW-1:0]            tgt_addr,
   input logic [DW-1:0]            lit_value,
   input logic                     sp_upd,
   input logic [DW-1:0]            sp_next,
   input logic                     pc_upd,
   input logic [DW-1:0]            pc_next,
   input logic                     extra_cycle
);

   logic [5:0]         c_q;
   logic               d_q;
   logic [NREG*DW-1:0] rf_q;
   logic [DW-1:0]      sp_q, pc_q, nw_q;
   logic               vld;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld <= 1'b0;
         else        vld <= 1'b1;
      end
      always_ff @(posedge clk) begin
         c_q  <= op_code;
         d_q  <= is_dest;
         rf_q <= reg_file;
         sp_q <= sp_in;
         pc_q <= pc_in;
         nw_q <= next_word;
      end
   end else begin : g_nodly
      assign vld  = 1'b1;
      assign c_q  = op_code;
      assign d_q  = is_dest;
      assign rf_q = reg_file;
      assign sp_q = sp_in;
      assign pc_q = pc_in;
      assign nw_q = next_word;
   end

   logic [DW-1:0] sel_val;
   assign sel_val = rf_q[int'(c_q[2:0])*DW +: DW];

   p_gpr_r1: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q < 6'h08) |-> (tgt_kind == 3'(TGT_REG) && tgt_reg == c_q[2:0]));

   p_ind_r2: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q[5:3] == 3'b001) |-> (tgt_kind == 3'(TGT_MEM) && tgt_addr == sel_val));

   p_idx_r3: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q[5:3] == 3'b010) |-> (tgt_addr == DW'(nw_q + sel_val) && pc_upd && extra_cycle));

   p_pop_r4: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q == 6'h18) |-> (tgt_addr == sp_q && sp_upd && sp_next == DW'(sp_q + DW'(1))));

   p_peek_r5: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q == 6'h19) |-> (tgt_addr == sp_q && !sp_upd));

   p_push_r6: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q == 6'h1A) |-> (tgt_addr == DW'(sp_q - DW'(1)) && sp_next == tgt_addr && sp_upd));

   p_short_lit_r10: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q[5] && !d_q) |-> (tgt_kind == 3'(TGT_LIT) && lit_value == DW'(c_q[4:0])));

   p_discard_r11: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (c_q >= 6'h1F && d_q) |-> (tgt_kind == 3'(TGT_DISCARD) && lit_value == '0));

   p_word_cost_r12: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      extra_cycle |-> (pc_upd && pc_next == DW'(pc_q + DW'(1))));

   p_no_pc_move_r12: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      !pc_upd |-> (pc_next == pc_q && !extra_cycle));

   p_mem_only_addr_r14: assert property (@(posedge clk) disable iff (!rst_n || !vld)
      (tgt_kind != 3'(TGT_MEM)) |-> (tgt_addr == '0));

endmodule

bind opr_resolver opr_resolver_chk #(.DW(DW), .NREG(NREG), .REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_code     (op_code),
   .is_dest     (is_dest),
   .reg_file    (reg_file),
   .sp_in       (sp_in),
   .pc_in       (pc_in),
   .next_word   (next_word),
   .tgt_kind    (tgt_kind),
   .tgt_reg     (tgt_reg),
   .tgt_addr    (tgt_addr),
   .lit_value   (lit_value),
   .sp_upd      (sp_upd),
   .sp_next     (sp_next),
   .pc_upd      (pc_upd),
   .pc_next     (pc_next),
   .extra_cycle (extra_cycle)
);

// File: tb/sim_opr_resolver.sv
`timescale 1ns/1ps
module sim_opr_resolver;

   localparam int DW   = 16;
   localparam int NREG = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [5:0]        op_code = '0;
   logic              is_dest = 1'b0;
   logic [NREG*DW-1:0] reg_file = '0;
   logic [DW-1:0]     sp_in = '0, pc_in = '0, next_word = '0;
   logic [2:0]        tgt_kind;
   logic [2:0]        tgt_reg;
   logic [DW-1:0]     tgt_addr, lit_value, sp_next, pc_next;
   logic              sp_upd, pc_upd, extra_cycle;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   opr_resolver #(.DW(DW), .NREG(NREG), .REG_OUT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .op_code(op_code), .is_dest(is_dest),
      .reg_file(reg_file), .sp_in(sp_in), .pc_in(pc_in), .next_word(next_word),
      .tgt_kind(tgt_kind), .tgt_reg(tgt_reg), .tgt_addr(tgt_addr),
      .lit_value(lit_value), .sp_upd(sp_upd), .sp_next(sp_next),
      .pc_upd(pc_upd), .pc_next(pc_next), .extra_cycle(extra_cycle)
   );

   logic [15:0] rv [8];

   function automatic logic [72:0] model(input logic [5:0] c, input logic d);
      logic [2:0]  k  = 3'd0;
      logic [2:0]  ri = 3'd0;
      logic [15:0] ad = 16'h0, lv = 16'h0;
      logic        su = 1'b0, pu = 1'b0, ex = 1'b0;
      logic [15:0] sn = sp_in, pn = pc_in;
      if (c < 6'h08) begin
         ri = c[2:0];
      end else if (c < 6'h10) begin
         k = 3'd4; ad = rv[c[2:0]];
      end else if (c < 6'h18) begin
         k = 3'd4; ad = next_word + rv[c[2:0]];
         pu = 1'b1; pn = pc_in + 16'd1; ex = 1'b1;
      end else if (c < 6'h20) begin
         case (c)
            6'h18: begin k = 3'd4; ad = sp_in; su = 1'b1; sn = sp_in + 16'd1; end
            6'h19: begin k = 3'd4; ad = sp_in; end
            6'h1A: begin k = 3'd4; ad = sp_in - 16'd1; su = 1'b1; sn = sp_in - 16'd1; end
            6'h1B: k = 3'd1;
            6'h1C: k = 3'd2;
            6'h1D: k = 3'd3;
            6'h1E: begin k = 3'd4; ad = next_word; pu = 1'b1; pn = pc_in + 16'd1; ex = 1'b1; end
            default: begin
               k = d ? 3'd6 : 3'd5; lv = d ? 16'h0 : next_word;
               pu = 1'b1; pn = pc_in + 16'd1; ex = 1'b1;
            end
         endcase
      end else begin
         k = d ? 3'd6 : 3'd5;
         lv = d ? 16'h0 : {11'h0, c[4:0]};
      end
      return {k, ri, ad, lv, su, sn, pu, pn, ex};
   endfunction

   function automatic string tag_of(input logic [5:0] c, input logic d);
      if (c < 6'h08) return "R1";
      if (c < 6'h10) return "R2";
      if (c < 6'h18) return "R3";
      if (c == 6'h18) return "R4";
      if (c == 6'h19) return "R5";
      if (c == 6'h1A) return "R6";
      if (c < 6'h1E) return "R7";
      if (c == 6'h1E) return "R8";
      if (d) return "R11";
      if (c == 6'h1F) return "R9";
      return "R10";
   endfunction

   function automatic logic [72:0] actual();
      return {tgt_kind, tgt_reg, tgt_addr, lit_value, sp_upd, sp_next, pc_upd, pc_next, extra_cycle};
   endfunction

   task automatic check(input string tag, input logic [72:0] act, input logic [72:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic load_pattern(input int p);
      for (int i = 0; i < 8; i++) begin
         case (p)
            0: rv[i] = 16'h0010 + 16'(i) * 16'h0101;
            1: rv[i] = 16'hFFF0 + 16'(i);
            2: rv[i] = 16'h8000 >> i;
            default: rv[i] = 16'hA5C3 ^ (16'(i) * 16'h1357);
         endcase
         reg_file[i*DW +: DW] = rv[i];
      end
      case (p)
         0: begin sp_in = 16'h8000; pc_in = 16'h0100; next_word = 16'h0040; end
         1: begin sp_in = 16'hFFFF; pc_in = 16'hFFFF; next_word = 16'h0020; end
         2: begin sp_in = 16'h0000; pc_in = 16'h1234; next_word = 16'hFFFF; end
         default: begin sp_in = 16'h0001; pc_in = 16'hFFFE; next_word = 16'hC001; end
      endcase
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
      $finish;
   end

   initial begin
      load_pattern(1);
      op_code = 6'h1F;
      is_dest = 1'b0;
      repeat (3) @(negedge clk);
      // R13: outputs held at zero during reset
      check("R13 reset", actual(), 73'h0);
      rst_n = 1'b1;
      @(negedge clk);
      load_pattern(0);
      op_code = 6'h03; is_dest = 1'b0;
      @(negedge clk);
      check("R1", actual(), model(6'h03, 1'b0));
      // R13: a new code must not show before the next clock edge
      op_code = 6'h1C;
      #1;
      check("R13 latency", actual(), model(6'h03, 1'b0));
      @(negedge clk);
      check("R7", actual(), model(6'h1C, 1'b0));

      for (int p = 0; p < 4; p++) begin
         load_pattern(p);
         for (int c = 0; c < 64; c++) begin
            for (int d = 0; d < 2; d++) begin
               op_code = 6'(c);
               is_dest = d[0];
               @(negedge clk);
               // every field compared: R12 side effects, R14 unused fields
               check({tag_of(6'(c), d[0]), " R12 R14"}, actual(), model(6'(c), d[0]));
            end
         end
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule